// File: doc/BRIEF.md
# Crossbar Linear-Leak Spiking Neuron Array

This block models a small population of digital integrate-and-fire neurons. They are driven by a binary connectivity crossbar and advance in discrete time steps. A step strobe captures one vector of axon spikes. The block then walks the crossbar one axon row per clock. For every set bit in the row of an active axon, it adds a signed multiplier to the connected neuron's membrane potential. Each neuron keeps three multipliers, and the type code of the driving axon picks one of them. After the last row, each neuron adds its own constant signed leak. The result is then compared with a shared threshold. A neuron whose potential is strictly above the threshold emits a spike, and its potential returns to zero.

The crossbar bits, the axon type codes, the per-neuron multipliers, the leaks and the threshold are all loaded through a simple write port. The spike vector produced at the end of a step can be wired back as the axon input of the next step, which gives recurrent networks. The membrane potentials saturate at the limits of their signed width and never wrap. The parameters must satisfy these conditions:
- the multiplier width must not exceed the potential width;
- the neuron count must not exceed the potential width;
- the crossbar row written through the data field must fit in that field.

Top module: `spike_xbar_array`

## Requirements
- R1: While reset is asserted and in the cycle after it, `spikeOut` is all zero and `done` and `busy` are low. All potentials and configuration values are cleared to zero.
- R2: A strobe accepted while idle raises `busy` in the next cycle. `done` pulses high for exactly one cycle, NUM_AXONS+1 cycles after the clock edge that sampled the strobe, and `busy` is low in that cycle.
- R3: For each active axon j and each neuron i whose crossbar bit (row j, bit i) is 1, neuron i adds its multiplier selected by axon j's type code. Type codes 0, 1 and 2 select multiplier slots 0, 1 and 2 (the `cfgSub` value used when writing a multiplier). A 0 crossbar bit or an inactive axon contributes nothing.
- R4: Every step, each neuron adds its signed leak after integration, even when no axon is active. The leaked value is the one compared with the threshold.
- R5: A neuron spikes only when its potential is strictly greater than the threshold. A potential equal to the threshold does not spike. A spiking neuron's potential becomes exactly 0.
- R6: Potentials saturate at the largest and smallest values of the signed POT_W-bit range instead of wrapping.
- R7: A write of type code 3 to an axon type leaves the stored code unchanged. A write of 0, 1 or 2 replaces it.
- R8: While `busy` is high, step strobes and configuration writes are ignored.
- R9: `spikeOut` changes only in the cycle where `done` is high, and holds its value until the next step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stepStrobe | input | 1 | Starts one time step when idle |
| axonIn | input | NUM_AXONS | Axon spike vector captured with the strobe |
| cfgWe | input | 1 | Configuration write enable |
| cfgKind | input | 3 | Target: 0 crossbar row, 1 axon type, 2 multiplier, 3 leak, 4 threshold |
| cfgAddr | input | AW | Axon index (kinds 0, 1) or neuron index (kinds 2, 3) |
| cfgSub | input | 2 | Multiplier slot 0..2 for kind 2 |
| cfgData | input | POT_W | Write data, signed for multiplier, leak and threshold |
| spikeOut | output | NUM_NEURONS | Spike vector of the last completed step |
| done | output | 1 | One-cycle pulse when a step completes |
| busy | output | 1 | High while a step is in progress |

## Verification
The result of a step is due in the cycle that follows NUM_AXONS+1 clock edges after the edge that sampled the strobe. During that span `busy` must be high and `done` low. The bench drives inputs on falling edges and counts falling edges from the strobe. It checks `busy` and `done` at each one and reads `spikeOut` only at the falling edge inside the `done` cycle. Potentials cannot be seen directly. Each test therefore chooses multipliers, leaks and a threshold so that the exact potential after each step shows up as spike or no spike in a later step. Equal-to-threshold, reset-to-zero and saturation are caught this way.

// File: rtl/sxa_pkg.sv
package sxa_pkg;

  typedef struct packed {
    logic latch;  // capture the axon vector, start a step
    logic accum;  // integrate the row under the row index
    logic fire;   // apply leak, compare, reset
  } stepCtrl_t;

  localparam logic [2:0] CFG_ROW  = 3'd0;
  localparam logic [2:0] CFG_TYPE = 3'd1;
  localparam logic [2:0] CFG_MULT = 3'd2;
  localparam logic [2:0] CFG_LEAK = 3'd3;
  localparam logic [2:0] CFG_THR  = 3'd4;

endpackage

// File: rtl/spike_xbar_ctrl.sv
module spike_xbar_ctrl
  import sxa_pkg::*;
#(
  parameter int NUM_AXONS = 8,
  localparam int RW = (NUM_AXONS > 1) ? $clog2(NUM_AXONS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stepStrobe,
  output stepCtrl_t     ctl,
  output logic [RW-1:0] rowIdx,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIRE} stepState_t;

  localparam logic [RW-1:0] LAST_ROW = RW'(NUM_AXONS - 1);

  stepState_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rowIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          rowIdx <= '0;
          if (stepStrobe) state <= ST_SCAN;
        end
        ST_SCAN: begin
          if (rowIdx == LAST_ROW) begin
            rowIdx <= '0;
            state  <= ST_FIRE;
          end else begin
            rowIdx <= rowIdx + 1'b1;
          end
        end
        ST_FIRE: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latch = (state == ST_IDLE) && stepStrobe;
    ctl.accum = (state == ST_SCAN);
    ctl.fire  = (state == ST_FIRE);
    busy      = (state != ST_IDLE);
  end

endmodule

// File: rtl/spike_xbar_datapath.sv
module spike_xbar_datapath
  import sxa_pkg::*;
#(
  parameter int NUM_AXONS   = 8,
  parameter int NUM_NEURONS = 4,
  parameter int WGT_W       = 8,
  parameter int POT_W       = 16,
  parameter int AW          = 3,
  localparam int RW = (NUM_AXONS > 1) ? $clog2(NUM_AXONS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  stepCtrl_t              ctl,
  input  logic [RW-1:0]          rowIdx,
  input  logic                   busy,
  input  logic [NUM_AXONS-1:0]   axonIn,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgKind,
  input  logic [AW-1:0]          cfgAddr,
  input  logic [1:0]             cfgSub,
  input  logic [POT_W-1:0]       cfgData,
  output logic [NUM_NEURONS-1:0] spikeOut
);

  localparam logic signed [POT_W-1:0] POT_MAX = {1'b0, {(POT_W-1){1'b1}}};
  localparam logic signed [POT_W-1:0] POT_MIN = {1'b1, {(POT_W-1){1'b0}}};

  logic [NUM_NEURONS-1:0]    xbarRow  [NUM_AXONS];
  logic [1:0]                axType   [NUM_AXONS];
  logic signed [WGT_W-1:0]   multTab  [NUM_NEURONS][3];
  logic signed [WGT_W-1:0]   leakTab  [NUM_NEURONS];
  logic signed [POT_W-1:0]   thresh;
  logic signed [POT_W-1:0]   pot      [NUM_NEURONS];
  logic [NUM_AXONS-1:0]      axLatch;

  function automatic logic signed [POT_W-1:0] satAdd(
    input logic signed [POT_W-1:0] a,
    input logic signed [WGT_W-1:0] b
  );
    logic signed [POT_W:0] s;
    s = {a[POT_W-1], a} + {{(POT_W+1-WGT_W){b[WGT_W-1]}}, b};
    if (s[POT_W] != s[POT_W-1]) return s[POT_W] ? POT_MIN : POT_MAX;
    return s[POT_W-1:0];
  endfunction

  // configuration store, frozen while a step runs
  wire cfgOk = cfgWe && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NUM_AXONS; j++) begin
        xbarRow[j] <= '0;
        axType[j]  <= 2'd0;
      end
      for (int i = 0; i < NUM_NEURONS; i++) begin
        for (int k = 0; k < 3; k++) multTab[i][k] <= '0;
        leakTab[i] <= '0;
      end
      thresh <= '0;
    end else if (cfgOk) begin
      case (cfgKind)
        CFG_ROW:
          if (int'(cfgAddr) < NUM_AXONS) xbarRow[cfgAddr] <= cfgData[NUM_NEURONS-1:0];
        CFG_TYPE:
          if (int'(cfgAddr) < NUM_AXONS && cfgData[1:0] != 2'd3) axType[cfgAddr] <= cfgData[1:0];
        CFG_MULT:
          if (int'(cfgAddr) < NUM_NEURONS && cfgSub != 2'd3) multTab[cfgAddr][cfgSub] <= cfgData[WGT_W-1:0];
        CFG_LEAK:
          if (int'(cfgAddr) < NUM_NEURONS) leakTab[cfgAddr] <= cfgData[WGT_W-1:0];
        CFG_THR:
          thresh <= cfgData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            axLatch <= '0;
    else if (ctl.latch) axLatch <= axonIn;
  end

  // row currently being integrated
  logic [NUM_NEURONS-1:0] curRow;
  logic [1:0]             curType;
  logic                   curActive;

  always_comb begin
    curRow    = xbarRow[rowIdx];
    curType   = axType[rowIdx];
    curActive = axLatch[rowIdx];
  end

  logic signed [POT_W-1:0] accNext  [NUM_NEURONS];
  logic signed [POT_W-1:0] leakNext [NUM_NEURONS];
  logic [NUM_NEURONS-1:0]  overThr;

  for (genvar n = 0; n < NUM_NEURONS; n++) begin : g_neuron
    logic signed [WGT_W-1:0] selW;
    logic signed [WGT_W-1:0] addend;

    always_comb begin
      case (curType)
        2'd1:    selW = multTab[n][1];
        2'd2:    selW = multTab[n][2];
        default: selW = multTab[n][0];
      endcase
      addend = (curActive && curRow[n]) ? selW : '0;
    end

    assign accNext[n]  = satAdd(pot[n], addend);
    assign leakNext[n] = satAdd(pot[n], leakTab[n]);
    assign overThr[n]  = leakNext[n] > thresh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_NEURONS; i++) pot[i] <= '0;
      spikeOut <= '0;
    end else if (ctl.accum) begin
      for (int i = 0; i < NUM_NEURONS; i++) pot[i] <= accNext[i];
    end else if (ctl.fire) begin
      for (int i = 0; i < NUM_NEURONS; i++) pot[i] <= overThr[i] ? '0 : leakNext[i];
      spikeOut <= overThr;
    end
  end

endmodule

// File: rtl/spike_xbar_array.sv
module spike_xbar_array
  import sxa_pkg::*;
#(
  parameter int NUM_AXONS   = 8,
  parameter int NUM_NEURONS = 4,
  parameter int WGT_W       = 8,
  parameter int POT_W       = 16,
  localparam int AMAX = (NUM_AXONS > NUM_NEURONS) ? NUM_AXONS : NUM_NEURONS,
  localparam int AW   = (AMAX > 1) ? $clog2(AMAX) : 1,
  localparam int RW   = (NUM_AXONS > 1) ? $clog2(NUM_AXONS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   stepStrobe,
  input  logic [NUM_AXONS-1:0]   axonIn,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgKind,
  input  logic [AW-1:0]          cfgAddr,
  input  logic [1:0]             cfgSub,
  input  logic [POT_W-1:0]       cfgData,
  output logic [NUM_NEURONS-1:0] spikeOut,
  output logic                   done,
  output logic                   busy
);

  stepCtrl_t     ctl;
  logic [RW-1:0] rowIdx;

  spike_xbar_ctrl #(.NUM_AXONS(NUM_AXONS)) u_ctrl (
    .clk(clk), .rst(rst), .stepStrobe(stepStrobe),
    .ctl(ctl), .rowIdx(rowIdx), .busy(busy), .done(done)
  );

  spike_xbar_datapath #(
    .NUM_AXONS(NUM_AXONS), .NUM_NEURONS(NUM_NEURONS),
    .WGT_W(WGT_W), .POT_W(POT_W), .AW(AW)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rowIdx(rowIdx), .busy(busy),
    .axonIn(axonIn), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgAddr(cfgAddr),
    .cfgSub(cfgSub), .cfgData(cfgData), .spikeOut(spikeOut)
  );

endmodule

// File: rtl/spike_xbar_array_chk.sv
module spike_xbar_array_chk #(
  parameter int NUM_AXONS   = 8,
  parameter int NUM_NEURONS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   stepStrobe,
  input logic                   busy,
  input logic                   done,
  input logic [NUM_NEURONS-1:0] spikeOut
);

  // cycles since the edge that accepted a strobe
  logic [31:0] sinceStrobe;

  always_ff @(posedge clk) begin
    if (rst)                      sinceStrobe <= '0;
    else if (stepStrobe && !busy) sinceStrobe <= '0;
    else if (busy)                sinceStrobe <= sinceStrobe + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (spikeOut == '0 && !done && !busy));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe && !busy) |=> busy);

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (sinceStrobe == 32'(NUM_AXONS + 1)));

  p_spike_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(spikeOut));

endmodule

bind spike_xbar_array spike_xbar_array_chk #(
  .NUM_AXONS(NUM_AXONS), .NUM_NEURONS(NUM_NEURONS)
) u_chk (
  .clk(clk), .rst(rst), .stepStrobe(stepStrobe),
  .busy(busy), .done(done), .spikeOut(spikeOut)
);

// File: tb/spike_xbar_array_tb.sv
module spike_xbar_array_tb;
  localparam int NA = 8;
  localparam int NN = 4;
  localparam int PW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stepStrobe = 1'b0;
  logic [NA-1:0] axonIn = '0;
  logic          cfgWe = 1'b0;
  logic [2:0]    cfgKind = '0;
  logic [AW-1:0] cfgAddr = '0;
  logic [1:0]    cfgSub = '0;
  logic [PW-1:0] cfgData = '0;
  logic [NN-1:0] spikeOut;
  logic          done;
  logic          busy;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spike_xbar_array u_dut (
    .clk(clk), .rst(rst), .stepStrobe(stepStrobe), .axonIn(axonIn),
    .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgAddr(cfgAddr), .cfgSub(cfgSub),
    .cfgData(cfgData), .spikeOut(spikeOut), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfgWrite(input logic [2:0] kind, input int addr, input int sub, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = kind; cfgAddr = AW'(addr); cfgSub = 2'(sub); cfgData = PW'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one step; timing of busy/done checked against R2 at each falling edge
  task automatic doStep(input logic [NA-1:0] ax, input bit disturb, output logic [NN-1:0] sp);
    bit timingOk = 1;
    @(negedge clk);
    stepStrobe = 1'b1; axonIn = ax;
    @(negedge clk);
    stepStrobe = 1'b0; axonIn = '0;
    for (int c = 1; c <= NA + 1; c++) begin
      if (disturb && c == 3) begin
        stepStrobe = 1'b0; cfgWe = 1'b0;
      end
      if (!(busy && !done)) timingOk = 0;
      if (disturb && c == 2) begin
        stepStrobe = 1'b1; axonIn = ax;
        cfgWe = 1'b1; cfgKind = 3'd0; cfgAddr = '0; cfgData = '0;
      end
      @(negedge clk);
    end
    if (!(done && !busy)) timingOk = 0;
    sp = spikeOut;
    @(negedge clk);
    if (done) timingOk = 0;
    chk(timingOk, "R2 done/busy timing", int'(timingOk), 1);
  endtask

  task automatic testReset();
    doReset();
    chk(spikeOut == '0, "R1 spikeOut after reset", int'(spikeOut), 0);
    chk(!done && !busy, "R1 done/busy after reset", int'({done, busy}), 0);
  endtask

  task automatic testIntegrate();
    logic [NN-1:0] sp;
    doReset();
    cfgWrite(3'd4, 0, 0, 10);
    cfgWrite(3'd0, 0, 0, 4'b0001); cfgWrite(3'd1, 0, 0, 0);
    cfgWrite(3'd0, 1, 0, 4'b0011); cfgWrite(3'd1, 1, 0, 1);
    cfgWrite(3'd0, 2, 0, 4'b1100); cfgWrite(3'd1, 2, 0, 2);
    cfgWrite(3'd2, 0, 0, 4);  cfgWrite(3'd2, 0, 1, -3);
    cfgWrite(3'd2, 1, 0, 50); cfgWrite(3'd2, 1, 1, 11);
    cfgWrite(3'd2, 2, 2, 20);
    cfgWrite(3'd2, 3, 0, 20); cfgWrite(3'd2, 3, 1, 20); cfgWrite(3'd2, 3, 2, 5);
    doStep(8'b0000_0111, 0, sp);
    chk(sp == 4'b0110, "R3 type select and crossbar gating", int'(sp), 6);
    doStep(8'b0000_0100, 0, sp);
    chk(sp == 4'b0100, "R3 single type-2 axon", int'(sp), 4);
    doStep(8'b0000_0000, 0, sp);
    chk(sp == 4'b0000, "R3 no active axon", int'(sp), 0);
  endtask

  task automatic testLeak();
    logic [NN-1:0] sp;
    doReset();
    cfgWrite(3'd4, 0, 0, 10);
    cfgWrite(3'd3, 0, 0, 4);
    cfgWrite(3'd3, 1, 0, -2);
    cfgWrite(3'd0, 0, 0, 4'b0010);
    cfgWrite(3'd2, 1, 0, 7);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0000, "R4 leak step 1", int'(sp), 0);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0000, "R4 leak step 2", int'(sp), 0);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0011, "R4 leak step 3 fires both", int'(sp), 3);
  endtask

  task automatic testThreshold();
    logic [NN-1:0] sp;
    logic [NN-1:0] held;
    doReset();
    cfgWrite(3'd4, 0, 0, 10);
    cfgWrite(3'd0, 0, 0, 4'b0011);
    cfgWrite(3'd2, 0, 0, 6);
    cfgWrite(3'd2, 1, 0, 5);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0000, "R5 below threshold", int'(sp), 0);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0001, "R5 equal does not fire", int'(sp), 1);
    held = sp;
    repeat (5) @(negedge clk);
    chk(spikeOut == held, "R9 spikeOut held between steps", int'(spikeOut), int'(held));
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0010, "R5 reset to zero after spike", int'(sp), 2);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0001, "R5 refire after reset", int'(sp), 1);
  endtask

  task automatic testSaturate();
    logic [NN-1:0] sp;
    bit earlyOk = 1;
    doReset();
    cfgWrite(3'd4, 0, 0, 32766);
    for (int j = 0; j < NA; j++) cfgWrite(3'd0, j, 0, 4'b0001);
    cfgWrite(3'd2, 0, 0, 127);
    for (int s = 0; s < 32; s++) begin
      doStep('1, 0, sp);
      if (sp != '0) earlyOk = 0;
    end
    chk(earlyOk, "R6 no spike before reaching the limit", int'(earlyOk), 1);
    doStep('1, 0, sp);
    chk(sp == 4'b0001, "R6 clamps at maximum instead of wrapping", int'(sp), 1);
  endtask

  task automatic testTypeCode();
    logic [NN-1:0] sp;
    doReset();
    cfgWrite(3'd4, 0, 0, 10);
    cfgWrite(3'd0, 0, 0, 4'b0001);
    cfgWrite(3'd2, 0, 0, 20);
    cfgWrite(3'd1, 0, 0, 3);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0001, "R7 type code 3 ignored", int'(sp), 1);
    cfgWrite(3'd1, 0, 0, 1);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0000, "R7 valid type code applied", int'(sp), 0);
  endtask

  task automatic testBusyIgnore();
    logic [NN-1:0] sp;
    bit quiet = 1;
    doReset();
    cfgWrite(3'd4, 0, 0, 10);
    cfgWrite(3'd0, 0, 0, 4'b0001);
    cfgWrite(3'd2, 0, 0, 6);
    doStep(8'b1, 1, sp);
    chk(sp == 4'b0000, "R8 first step result", int'(sp), 0);
    for (int c = 0; c < NA + 3; c++) begin
      if (done || busy) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R8 strobe during busy started no step", int'(quiet), 1);
    doStep(8'b1, 0, sp);
    chk(sp == 4'b0001, "R8 crossbar write during busy ignored", int'(sp), 1);
  endtask

  initial begin
    testReset();
    testIntegrate();
    testLeak();
    testThreshold();
    testSaturate();
    testTypeCode();
    testBusyIgnore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule